// File: doc/BRIEF.md
# Memory-Backed Command Queue Front End

This block sits between a host that issues 32-bit register-space writes and a graphics memory that holds a command queue. While queue mode is on, host writes that land in the queue aperture are not treated as register writes. Each one becomes a store into a window of shared graphics memory, and a word counter counts it. A downstream command parser takes the stored words back one at a time through a valid/ready pop port. For each pop the block fetches the word at the read pointer, advances the pointer by four bytes and lowers the count.

The block also holds the control registers of the queue: mode, window base/end, read pointer, word count and two threshold registers. It forwards every other register write to the register file behind it. While queue mode is on, only registers with the write-through attribute are forwarded and all other direct writes are dropped. A combinational read port returns the control registers and a status word whose busy field is set while the queue is enabled and holds data.

Top module: `memq_front`

## Requirements
- R1: Queue mode is on only when mode register (index 0x10) bit 0 (enable) and bit 1 (memory store) are both 1. A host write made while enable is 1 and memory store is 0 pulses `mode_err` in that cycle, makes no store and is handled as a plain register write.
- R2: In queue mode a host write with offset bit 19 set drives `mem_wr_en` in the same cycle. Its address is (base + offset[15:0]*4) modulo 2^MEM_AW, its data is the host data, and the word count rises by one at the clock edge.
- R3: In queue mode a write without offset bit 19 is forwarded on `reg_wr_en` only if its index (offset[7:0]) is write-through. Write-through covers indices WT_LO..WT_HI (default 0x20..0x2F) and the block's own control registers 0x10..0x15; other writes are dropped. Outside queue mode every write that does not hit a control register is forwarded.
- R4: A write to the window register (0x11) sets base = data[9:0]*4096 and end = data[25:16]*4096. It reads back as {6'b0, end field, 6'b0, base field}.
- R5: The read-pointer register (0x12) stores all 32 data bits. The word-count register (0x13) stores data[15:0] only. Both read back zero-extended.
- R6: `pop_valid` is 1 only when the count is non-zero and the word at (read pointer modulo 2^MEM_AW) has returned from memory. A pop (valid and ready) delivers that word, adds 4 to the read pointer and lowers the count by one. With a count of zero no word is offered.
- R7: The status word (index 0x00) has bits 9:7 = 3'b111 when mode bit 0 is 1 and the count is non-zero, and 3'b000 otherwise. All other status bits are 0.
- R8: The low and high threshold registers (0x14, 0x15) keep all 32 written bits and read them back unchanged.
- R9: A store and a pop in the same cycle leave the count unchanged. A host write to the count register in the same cycle as a store or pop sets the count to the written value.
- R10: A host write to the read pointer or the count discards any word already fetched. The next word offered is read from the new read pointer.
- R11: After reset the mode, window, pointer, count and threshold registers read 0 and `pop_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_ofs | input | 20 | Host word offset; bit 19 selects the queue aperture |
| host_wr_data | input | 32 | Host write data |
| host_rd_idx | input | 8 | Control register index to read |
| host_rd_data | output | 32 | Read data of the selected control register |
| reg_wr_en | output | 1 | Forwarded register write strobe |
| reg_wr_ofs | output | 20 | Forwarded write offset |
| reg_wr_data | output | 32 | Forwarded write data |
| mode_err | output | 1 | Write made in the unsupported non-store queue variant |
| mem_wr_en | output | 1 | Queue store strobe |
| mem_wr_addr | output | 22 | Queue store byte address |
| mem_wr_data | output | 32 | Queue store data |
| mem_rd_en | output | 1 | Fetch request |
| mem_rd_addr | output | 22 | Fetch byte address |
| mem_rd_valid | input | 1 | Fetch data returned |
| mem_rd_data | input | 32 | Fetched word |
| pop_valid | output | 1 | A queue word is offered |
| pop_ready | input | 1 | Consumer accepts the offered word |
| pop_data | output | 32 | Offered queue word |

## Verification
On every cycle the assertions check how the count and read pointer step for stores, pops, simultaneous store-and-pop and count overrides. They also check that a word is never offered from an empty queue, that forwarded writes never coincide with stores, and that the busy field follows a store. Only the bench scenarios show the actual store addresses, including wrap at the top of memory. The same holds for the data order seen by the consumer, for register readback, for dropping of non-write-through writes, and for the discarding of a fetched word after a pointer rewrite.

// File: rtl/memq_pkg.sv
package memq_pkg;
  typedef logic [7:0] reg_idx_t;

  localparam reg_idx_t IDX_STAT  = 8'h00;
  localparam reg_idx_t IDX_CFG   = 8'h10;
  localparam reg_idx_t IDX_WIN   = 8'h11;
  localparam reg_idx_t IDX_RPTR  = 8'h12;
  localparam reg_idx_t IDX_DEPTH = 8'h13;
  localparam reg_idx_t IDX_TMIN  = 8'h14;
  localparam reg_idx_t IDX_TMAX  = 8'h15;

  localparam int NUM_TH        = 2;
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_STORE_BIT = 1;
  localparam int WIN_FLD_W     = 10;
  localparam int WIN_SHIFT     = 12;
  localparam int END_LSB       = 16;
  localparam int BUSY_LSB      = 7;
  localparam int BUSY_W        = 3;

  typedef struct packed {
    logic              cfg;
    logic              win;
    logic              rptr;
    logic              depth;
    logic [NUM_TH-1:0] th;
  } own_wr_t;
endpackage

// File: rtl/memq_decode.sv
module memq_decode
  import memq_pkg::*;
#(
  parameter int       MEM_AW = 22,
  parameter reg_idx_t WT_LO  = 8'h20,
  parameter reg_idx_t WT_HI  = 8'h2F
) (
  input  logic                 wr_en,
  input  logic                 wr_apt,
  input  logic [15:0]          wr_low,
  input  logic                 mode_en,
  input  logic                 mode_store,
  input  logic [WIN_FLD_W-1:0] base_fld,
  output logic                 st_en,
  output logic [MEM_AW-1:0]    st_addr,
  output logic                 err,
  output logic                 fwd_en,
  output own_wr_t              own_wr
);
  logic     mode_on;
  logic     is_own;
  logic     in_wt;
  logic     pass;
  reg_idx_t idx;
  logic [MEM_AW-1:0] base_addr;
  logic [MEM_AW-1:0] ofs_addr;

  always_comb begin
    idx     = wr_low[7:0];
    mode_on = mode_en & mode_store;
    st_en   = wr_en & mode_on & wr_apt;
    err     = wr_en & mode_en & ~mode_store;
    is_own  = (idx >= IDX_CFG) && (idx <= IDX_TMAX);
    in_wt   = is_own | ((idx >= WT_LO) && (idx <= WT_HI));
    pass    = wr_en & ~st_en & (~mode_on | in_wt);
    fwd_en  = pass & ~is_own;

    own_wr.cfg   = pass & (idx == IDX_CFG);
    own_wr.win   = pass & (idx == IDX_WIN);
    own_wr.rptr  = pass & (idx == IDX_RPTR);
    own_wr.depth = pass & (idx == IDX_DEPTH);
    for (int k = 0; k < NUM_TH; k++) begin
      own_wr.th[k] = pass & (idx == reg_idx_t'(IDX_TMIN + k));
    end
  end

  // Address arithmetic truncates to MEM_AW bits, which applies the memory mask.
  always_comb begin
    base_addr = MEM_AW'({base_fld, {WIN_SHIFT{1'b0}}});
    ofs_addr  = MEM_AW'({wr_low, 2'b00});
    st_addr   = base_addr + ofs_addr;
  end
endmodule

// File: rtl/memq_regs.sv
module memq_regs
  import memq_pkg::*;
#(
  parameter int DEPTH_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  own_wr_t              own_wr,
  input  logic [31:0]          wr_data,
  input  reg_idx_t             rd_idx,
  input  logic [31:0]          rdptr,
  input  logic [DEPTH_W-1:0]   depth,
  output logic                 mode_en,
  output logic                 mode_store,
  output logic [WIN_FLD_W-1:0] base_fld,
  output logic [31:0]          stat_word,
  output logic [31:0]          rd_data
);
  localparam int PAD_W = 16 - WIN_FLD_W;

  logic [1:0]           cfg_q, cfg_d;
  logic [WIN_FLD_W-1:0] base_q, base_d;
  logic [WIN_FLD_W-1:0] end_q, end_d;
  logic [31:0]          th_q [NUM_TH];

  always_comb begin
    cfg_d  = {wr_data[CFG_STORE_BIT], wr_data[CFG_EN_BIT]};
    base_d = wr_data[WIN_FLD_W-1:0];
    end_d  = wr_data[END_LSB +: WIN_FLD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (own_wr.cfg) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      end_q  <= '0;
    end else if (own_wr.win) begin
      base_q <= base_d;
      end_q  <= end_d;
    end
  end

  for (genvar g = 0; g < NUM_TH; g++) begin : g_th
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        th_q[g] <= '0;
      end else if (own_wr.th[g]) begin
        th_q[g] <= wr_data;
      end
    end
  end

  assign mode_en    = cfg_q[0];
  assign mode_store = cfg_q[1];
  assign base_fld   = base_q;

  always_comb begin
    stat_word = '0;
    if (cfg_q[0] && (depth != '0)) begin
      stat_word[BUSY_LSB +: BUSY_W] = '1;
    end
  end

  always_comb begin
    unique case (rd_idx)
      IDX_STAT:  rd_data = stat_word;
      IDX_CFG:   rd_data = {30'b0, cfg_q};
      IDX_WIN:   rd_data = {{PAD_W{1'b0}}, end_q, {PAD_W{1'b0}}, base_q};
      IDX_RPTR:  rd_data = rdptr;
      IDX_DEPTH: rd_data = 32'(depth);
      IDX_TMIN:  rd_data = th_q[0];
      IDX_TMAX:  rd_data = th_q[1];
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/memq_ptrs.sv
module memq_ptrs #(
  parameter int DEPTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_rptr,
  input  logic               wr_depth,
  input  logic [31:0]        rptr_wdata,
  input  logic [DEPTH_W-1:0] depth_wdata,
  input  logic               push,
  input  logic               pop,
  output logic [31:0]        rdptr,
  output logic [DEPTH_W-1:0] depth,
  output logic               depth_nz,
  output logic               flush
);
  localparam logic [31:0]        PTR_STEP = 32'd4;
  localparam logic [DEPTH_W-1:0] ONE      = DEPTH_W'(1);

  logic [31:0]        rdptr_q, rdptr_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;

  always_comb begin
    rdptr_d = rdptr_q;
    if (wr_rptr) begin
      rdptr_d = rptr_wdata;
    end else if (pop) begin
      rdptr_d = rdptr_q + PTR_STEP;
    end
  end

  always_comb begin
    depth_d = depth_q;
    if (wr_depth) begin
      depth_d = depth_wdata;
    end else if (push && !pop) begin
      depth_d = depth_q + ONE;
    end else if (pop && !push) begin
      depth_d = depth_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdptr_q <= '0;
      depth_q <= '0;
    end else begin
      rdptr_q <= rdptr_d;
      depth_q <= depth_d;
    end
  end

  assign rdptr    = rdptr_q;
  assign depth    = depth_q;
  assign depth_nz = (depth_q != '0);
  assign flush    = wr_rptr | wr_depth;
endmodule

// File: rtl/memq_fetch.sv
module memq_fetch #(
  parameter int MEM_AW = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              depth_nz,
  input  logic [MEM_AW-1:0] rd_addr_in,
  input  logic              flush,
  input  logic              pop_ready,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  output logic              pop_valid,
  output logic [31:0]       pop_data,
  output logic              pop_fire
);
  logic        hold_q, hold_d;
  logic        pend_q, pend_d;
  logic        stale_q, stale_d;
  logic [31:0] data_q, data_d;
  logic        issue;
  logic        data_ld;

  always_comb begin
    pop_valid = hold_q & depth_nz;
    pop_fire  = pop_valid & pop_ready;
    issue     = ~hold_q & ~pend_q & depth_nz & ~flush;

    hold_d  = hold_q;
    pend_d  = pend_q;
    stale_d = stale_q;
    data_d  = data_q;
    data_ld = 1'b0;

    if (pop_fire || flush) begin
      hold_d = 1'b0;
    end
    if (issue) begin
      pend_d = 1'b1;
    end
    if (pend_q && mem_rd_valid) begin
      pend_d  = 1'b0;
      stale_d = 1'b0;
      if (!stale_q && !flush) begin
        hold_d  = 1'b1;
        data_d  = mem_rd_data;
        data_ld = 1'b1;
      end
    end else if (pend_q && flush) begin
      stale_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      pend_q  <= pend_d;
      stale_q <= stale_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_ld) begin
      data_q <= data_d;
    end
  end

  assign mem_rd_en   = issue;
  assign mem_rd_addr = rd_addr_in;
  assign pop_data    = data_q;
endmodule

// File: rtl/memq_front.sv
module memq_front
  import memq_pkg::*;
#(
  parameter int       OFS_W   = 20,
  parameter int       MEM_AW  = 22,
  parameter int       DEPTH_W = 16,
  parameter reg_idx_t WT_LO   = 8'h20,
  parameter reg_idx_t WT_HI   = 8'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [OFS_W-1:0]  host_wr_ofs,
  input  logic [31:0]       host_wr_data,
  input  logic [7:0]        host_rd_idx,
  output logic [31:0]       host_rd_data,
  output logic              reg_wr_en,
  output logic [OFS_W-1:0]  reg_wr_ofs,
  output logic [31:0]       reg_wr_data,
  output logic              mode_err,
  output logic              mem_wr_en,
  output logic [MEM_AW-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [31:0]       pop_data
);
  localparam int APT_BIT = OFS_W - 1;

  logic [1:0]           rs_q;
  logic                 rst_sync_n;
  logic                 mode_en;
  logic                 mode_store;
  logic [WIN_FLD_W-1:0] base_fld;
  logic [31:0]          stat_word;
  logic [31:0]          rdptr_q;
  logic [DEPTH_W-1:0]   depth_q;
  logic                 depth_nz;
  logic                 flush;
  logic                 pop_fire;
  logic                 st_en;
  logic                 fwd_en;
  own_wr_t              own_wr;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  memq_decode #(
    .MEM_AW (MEM_AW),
    .WT_LO  (WT_LO),
    .WT_HI  (WT_HI)
  ) u_decode (
    .wr_en      (host_wr_en),
    .wr_apt     (host_wr_ofs[APT_BIT]),
    .wr_low     (host_wr_ofs[15:0]),
    .mode_en    (mode_en),
    .mode_store (mode_store),
    .base_fld   (base_fld),
    .st_en      (st_en),
    .st_addr    (mem_wr_addr),
    .err        (mode_err),
    .fwd_en     (fwd_en),
    .own_wr     (own_wr)
  );

  memq_regs #(
    .DEPTH_W (DEPTH_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .own_wr     (own_wr),
    .wr_data    (host_wr_data),
    .rd_idx     (host_rd_idx),
    .rdptr      (rdptr_q),
    .depth      (depth_q),
    .mode_en    (mode_en),
    .mode_store (mode_store),
    .base_fld   (base_fld),
    .stat_word  (stat_word),
    .rd_data    (host_rd_data)
  );

  memq_ptrs #(
    .DEPTH_W (DEPTH_W)
  ) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_rptr     (own_wr.rptr),
    .wr_depth    (own_wr.depth),
    .rptr_wdata  (host_wr_data),
    .depth_wdata (host_wr_data[DEPTH_W-1:0]),
    .push        (st_en),
    .pop         (pop_fire),
    .rdptr       (rdptr_q),
    .depth       (depth_q),
    .depth_nz    (depth_nz),
    .flush       (flush)
  );

  memq_fetch #(
    .MEM_AW (MEM_AW)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .depth_nz     (depth_nz),
    .rd_addr_in   (rdptr_q[MEM_AW-1:0]),
    .flush        (flush),
    .pop_ready    (pop_ready),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .pop_valid    (pop_valid),
    .pop_data     (pop_data),
    .pop_fire     (pop_fire)
  );

  assign reg_wr_en   = fwd_en;
  assign reg_wr_ofs  = host_wr_ofs;
  assign reg_wr_data = host_wr_data;
  assign mem_wr_en   = st_en;
  assign mem_wr_data = host_wr_data;
endmodule

// File: rtl/memq_front_chk.sv
module memq_front_chk #(
  parameter int DEPTH_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_wr_en,
  input logic               apt,
  input logic [DEPTH_W-1:0] depth_wdata,
  input logic               reg_wr_en,
  input logic               mode_err,
  input logic               mem_wr_en,
  input logic               pop_valid,
  input logic               pop_fire,
  input logic [DEPTH_W-1:0] depth,
  input logic [31:0]        rdptr,
  input logic               wr_depth,
  input logic               wr_rptr,
  input logic [2:0]         busy
);
  assert_store_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (host_wr_en && apt && !mode_err));

  assert_depth_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !pop_fire && !wr_depth) |=> (depth == $past(depth) + 1'b1));

  assert_push_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && pop_fire && !wr_depth) |=> $stable(depth));

  assert_depth_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_depth |=> (depth == $past(depth_wdata)));

  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (depth != '0));

  assert_rdptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !wr_rptr) |=> (rdptr == $past(rdptr) + 32'd4));

  assert_fwd_not_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (host_wr_en && !mem_wr_en));

  assert_err_no_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !mem_wr_en);

  assert_busy_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !wr_depth) |=> (busy == 3'b111));
endmodule

bind memq_front memq_front_chk #(
  .DEPTH_W (DEPTH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .host_wr_en  (host_wr_en),
  .apt         (host_wr_ofs[OFS_W-1]),
  .depth_wdata (host_wr_data[DEPTH_W-1:0]),
  .reg_wr_en   (reg_wr_en),
  .mode_err    (mode_err),
  .mem_wr_en   (mem_wr_en),
  .pop_valid   (pop_valid),
  .pop_fire    (pop_fire),
  .depth       (depth_q),
  .rdptr       (rdptr_q),
  .wr_depth    (own_wr.depth),
  .wr_rptr     (own_wr.rptr),
  .busy        (stat_word[9:7])
);

// File: tb/memq_front_tb.sv
`timescale 1ns/1ps
module memq_front_tb;
  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [19:0] host_wr_ofs;
  logic [31:0] host_wr_data;
  logic [7:0]  host_rd_idx;
  logic [31:0] host_rd_data;
  logic        reg_wr_en;
  logic [19:0] reg_wr_ofs;
  logic [31:0] reg_wr_data;
  logic        mode_err;
  logic        mem_wr_en;
  logic [21:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        mem_rd_en;
  logic [21:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        pop_valid;
  logic        pop_ready;
  logic [31:0] pop_data;

  int n_chk;
  int n_bad;
  bit done;

  logic [31:0] bmem [0:4095];
  logic [31:0] qexp [0:2047];
  int head;
  int tail;

  logic        ob_mwe, ob_rwe, ob_err;
  logic [21:0] ob_maddr;

  memq_front u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0;
    end else begin
      mem_rd_valid <= mem_rd_en;
      if (mem_rd_en) mem_rd_data <= bmem[mem_rd_addr[13:2]];
      if (mem_wr_en) bmem[mem_wr_addr[13:2]] <= mem_wr_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] val);
    host_rd_idx = idx;
    #1;
    val = host_rd_data;
  endtask

  task automatic hwr(input logic [19:0] ofs, input logic [31:0] d);
    host_wr_en = 1'b1; host_wr_ofs = ofs; host_wr_data = d;
    #1;
    ob_mwe = mem_wr_en; ob_maddr = mem_wr_addr; ob_rwe = reg_wr_en; ob_err = mode_err;
    @(posedge clk); @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  function automatic logic [31:0] win_read(input logic [9:0] b, input logic [9:0] e);
    return {6'b0, e, 6'b0, b};
  endfunction

  function automatic logic [21:0] st_addr(input logic [9:0] b, input logic [15:0] o);
    return 22'({b, 12'h000}) + 22'({o, 2'b00});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    n_chk = 0; n_bad = 0; done = 0; head = 0; tail = 0;
    host_wr_en = 0; host_wr_ofs = '0; host_wr_data = '0; host_rd_idx = '0;
    pop_ready = 0; mem_rd_data = '0;
    for (int i = 0; i < 4096; i++) bmem[i] = 32'hBAD0_0000 | 32'(i);
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R11 reset state
    rd(8'h10, v); chk("R11 mode", v, 32'h0);
    rd(8'h11, v); chk("R11 window", v, 32'h0);
    rd(8'h12, v); chk("R11 rdptr", v, 32'h0);
    rd(8'h13, v); chk("R11 count", v, 32'h0);
    rd(8'h14, v); chk("R11 thmin", v, 32'h0);
    chk("R11 pop_valid", 32'(pop_valid), 32'h0);

    // R3 plain mode forwards everything else
    hwr(20'h00040, 32'h1111_2222);
    chk("R3 forward off-mode", 32'(ob_rwe), 32'h1);
    hwr(20'h80040, 32'h3333);
    chk("R1 no store off-mode", 32'(ob_mwe), 32'h0);

    // R1 enable without memory store
    hwr(20'h00010, 32'h1);
    hwr(20'h80040, 32'h4444);
    chk("R1 err pulse", 32'(ob_err), 32'h1);
    chk("R1 no store", 32'(ob_mwe), 32'h0);
    chk("R1 plain write", 32'(ob_rwe), 32'h1);
    rd(8'h13, v); chk("R1 count", v, 32'h0);

    // R4 window and R8 thresholds
    hwr(20'h00011, 32'hFC3F_FD55);
    rd(8'h11, v); chk("R4 window readback", v, win_read(10'h155, 10'h03F));
    hwr(20'h00014, 32'hA5A5_0F0F);
    hwr(20'h00015, 32'h0123_4567);
    rd(8'h14, v); chk("R8 thmin", v, 32'hA5A5_0F0F);
    rd(8'h15, v); chk("R8 thmax", v, 32'h0123_4567);

    // R3 queue mode filtering
    hwr(20'h00010, 32'h3);
    hwr(20'h00040, 32'h5555);
    chk("R3 dropped", 32'(ob_rwe), 32'h0);
    chk("R3 dropped no store", 32'(ob_mwe), 32'h0);
    hwr(20'h00025, 32'h6666);
    chk("R3 write-through", 32'(ob_rwe), 32'h1);
    chk("R1 no err full mode", 32'(ob_err), 32'h0);

    // R2 store address with wrap, R7 busy
    hwr(20'h00011, 32'h0000_03FF);
    hwr(20'h8FFFF, 32'hCAFE_F00D);
    chk("R2 store strobe", 32'(ob_mwe), 32'h1);
    chk("R2 store wrap addr", 32'(ob_maddr), 32'(st_addr(10'h3FF, 16'hFFFF)));
    chk("R2 store not forwarded", 32'(ob_rwe), 32'h0);
    rd(8'h13, v); chk("R2 count", v, 32'h1);
    rd(8'h00, v); chk("R7 busy", v, 32'h0000_0380);

    // R5 pointer and count registers
    hwr(20'h00013, 32'hABCD_1234);
    rd(8'h13, v); chk("R5 count width", v, 32'h0000_1234);
    hwr(20'h00012, 32'hDEAD_BEEF);
    rd(8'h12, v); chk("R5 rdptr full", v, 32'hDEAD_BEEF);
    hwr(20'h00013, 32'h0);
    hwr(20'h00012, 32'h0);
    rd(8'h00, v); chk("R7 idle status", v, 32'h0);
    idle(4);
    chk("R6 empty no valid", 32'(pop_valid), 32'h0);

    // random store/pop traffic
    hwr(20'h00011, 32'h0);
    for (int c = 0; c < 900; c++) begin
      bit   do_push;
      bit   fire;
      logic [31:0] d;
      do_push = ((tail - head) < 40) && ($urandom % 3 != 0);
      d = $urandom;
      pop_ready = ($urandom % 2) == 1;
      host_wr_en = do_push; host_wr_ofs = {4'h8, 16'(tail)}; host_wr_data = d;
      #1;
      fire = pop_valid && pop_ready;
      if (fire) chk("R6 pop data", pop_data, qexp[head[10:0]]);
      @(posedge clk); @(negedge clk);
      host_wr_en = 0; pop_ready = 0;
      if (do_push) begin qexp[tail[10:0]] = d; tail++; end
      if (fire) head++;
      if (c % 150 == 149) begin
        rd(8'h13, v); chk("R6 count tracks", v, 32'(tail - head));
        rd(8'h12, v); chk("R6 rdptr tracks", v, 32'(head * 4));
      end
    end

    // R9 simultaneous store and pop
    for (int k = 0; k < 3; k++) begin
      logic [31:0] d;
      d = $urandom;
      hwr({4'h8, 16'(tail)}, d);
      qexp[tail[10:0]] = d; tail++;
    end
    idle(6);
    chk("R6 valid when filled", 32'(pop_valid), 32'h1);
    begin
      logic [31:0] d;
      d = 32'h5A5A_1234;
      host_wr_en = 1; host_wr_ofs = {4'h8, 16'(tail)}; host_wr_data = d; pop_ready = 1;
      #1;
      chk("R9 popped word", pop_data, qexp[head[10:0]]);
      @(posedge clk); @(negedge clk);
      host_wr_en = 0; pop_ready = 0;
      qexp[tail[10:0]] = d; tail++; head++;
      rd(8'h13, v); chk("R9 count unchanged", v, 32'(tail - head));
    end

    // R10 pointer rewrite discards fetched word
    idle(6);
    hwr(20'h00012, 32'((head + 1) * 4));
    hwr(20'h00013, 32'(tail - head - 1));
    head++;
    idle(6);
    chk("R10 valid after rewrite", 32'(pop_valid), 32'h1);
    chk("R10 refetched word", pop_data, qexp[head[10:0]]);

    // R9 count write overrides a pop
    host_wr_en = 1; host_wr_ofs = 20'h00013; host_wr_data = 32'h0000_0009; pop_ready = 1;
    #1;
    chk("R9 pop under override", 32'(pop_valid), 32'h1);
    @(posedge clk); @(negedge clk);
    host_wr_en = 0; pop_ready = 0;
    head++;
    rd(8'h13, v); chk("R9 override count", v, 32'h9);
    rd(8'h12, v); chk("R6 rdptr after pop", v, 32'(head * 4));

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule